// File: doc/BRIEF.md
# Ternary Raster Operation Unit

This block is the pixel combiner of an 8-bit-per-pixel blitter. Each cycle it may accept one destination pixel, one source pixel and one pattern pixel. It also takes two 8-bit raster operation codes, one foreground and one background, plus a mix byte, the current X coordinate and a flag giving the X direction. It returns the combined pixel one clock later.

The mix byte chooses the code for each pixel. The bit of the mix byte that is used follows the X coordinate, counted from the other end when X runs downward. Within the chosen code, each result bit is looked up with a 3-bit index. The index is formed from the matching bits of the three operands.

The block does no memory access, address stepping or sequencing. The engine around it supplies one pixel per cycle and writes the result back. When the engine has no mix data it clears the mix-enable input, and the foreground code then applies to every pixel.

Top module: `tern_rop_unit`

## Requirements
- R1: While reset is high and after it is released with no accepted pixel, `out_valid` is 0 and `out_px` is 0.
- R2: `out_valid` equals `in_valid` of the previous clock edge, so one accepted pixel produces exactly one result one cycle later.
- R3: Result bit i equals bit k of the selected code, where k = pattern[i]*4 + source[i]*2 + destination[i]. Pattern is the most significant index bit and destination the least significant.
- R4: With `mix_en` = 1, a selected mix bit of 1 chooses `fg_rop` and a selected mix bit of 0 chooses `bg_rop`.
- R5: When `x_neg` = 0 the selected mix bit is `mix_map[x_pos mod 8]`.
- R6: When `x_neg` = 1 the selected mix bit is `mix_map[7 - (x_pos mod 8)]`.
- R7: With `mix_en` = 0 the mix byte is treated as all ones: `fg_rop` is used whatever `mix_map`, `bg_rop` and `x_pos` hold.
- R8: In a cycle with `in_valid` = 0 the data inputs have no effect. `out_px` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on this cycle are to be combined |
| dst_px | input | 8 | Destination pixel |
| src_px | input | 8 | Source pixel |
| pat_px | input | 8 | Pattern pixel |
| fg_rop | input | 8 | Foreground raster operation code |
| bg_rop | input | 8 | Background raster operation code |
| mix_map | input | 8 | Mix byte choosing foreground or background per pixel |
| mix_en | input | 1 | 1: use mix_map; 0: mix byte taken as all ones |
| x_pos | input | 16 | Current X coordinate of the pixel |
| x_neg | input | 1 | 1: X runs in the negative direction |
| out_valid | output | 1 | Result pixel valid |
| out_px | output | 8 | Result pixel |

## Verification
The assertions assume that every input is stable and known across each clock edge while reset is low. Their code-selection properties also assume that the engine presents the pair 0xFF/0x00 unchanged for a whole cycle. In that case the result shows the chosen mix bit directly. The bench changes inputs only on the falling edge and draws every operand from the full 8-bit range. Between accepted pixels it scrambles the data inputs with `in_valid` low, so every input stays legal while the hold behaviour is still exercised.

// File: rtl/tern_rop_pkg.sv
package tern_rop_pkg;
  // Number of operand pixels feeding each lookup index.
  localparam int unsigned OPND_N = 3;
  // A raster operation code holds one result bit per index value.
  localparam int unsigned CODE_W = 1 << OPND_N;
  typedef logic [CODE_W-1:0] rop_code_t;

  // Index positions whose destination bit is 0 or 1.
  localparam rop_code_t DST_LO = 8'h55;
  localparam rop_code_t DST_HI = 8'hAA;
  // Index positions whose source bit is 0 or 1.
  localparam rop_code_t SRC_LO = 8'h33;
  localparam rop_code_t SRC_HI = 8'hCC;
  // Index positions whose pattern bit is 0 or 1.
  localparam rop_code_t PAT_LO = 8'h0F;
  localparam rop_code_t PAT_HI = 8'hF0;
endpackage

// File: rtl/trop_code_select.sv
module trop_code_select
  import tern_rop_pkg::*;
#(
  parameter int unsigned MIX_W = 8,
  parameter int unsigned X_W   = 16,
  localparam int unsigned IW   = $clog2(MIX_W)
) (
  input  rop_code_t        fg_rop,
  input  rop_code_t        bg_rop,
  input  logic [MIX_W-1:0] mix_map,
  input  logic             mix_en,
  input  logic [X_W-1:0]   x_pos,
  input  logic             x_neg,
  output rop_code_t        code
);
  logic [IW-1:0] lane;
  logic [IW-1:0] pick;
  logic          use_fg;

  always_comb begin
    lane = IW'(x_pos % X_W'(MIX_W));
    // A descending walk reads the mix byte from its far end.
    pick = x_neg ? IW'(MIX_W - 1) - lane : lane;
    use_fg = mix_en ? mix_map[pick] : 1'b1;
    code = use_fg ? fg_rop : bg_rop;
  end
endmodule

// File: rtl/trop_bit_eval.sv
module trop_bit_eval
  import tern_rop_pkg::*;
(
  input  rop_code_t code,
  input  logic      d,
  input  logic      s,
  input  logic      p,
  output logic      y
);
  rop_code_t hit;

  // Each operand keeps the index positions that agree with its bit value.
  // Only the single position matching all three survives the AND.
  always_comb begin
    hit = code & (d ? DST_HI : DST_LO)
               & (s ? SRC_HI : SRC_LO)
               & (p ? PAT_HI : PAT_LO);
    y = |hit;
  end
endmodule

// File: rtl/trop_combiner.sv
module trop_combiner
  import tern_rop_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  rop_code_t        code,
  input  logic [PIX_W-1:0] dst,
  input  logic [PIX_W-1:0] src,
  input  logic [PIX_W-1:0] pat,
  output logic [PIX_W-1:0] res
);
  for (genvar b = 0; b < PIX_W; b++) begin : g_bit
    trop_bit_eval u_bit (
      .code (code),
      .d    (dst[b]),
      .s    (src[b]),
      .p    (pat[b]),
      .y    (res[b])
    );
  end
endmodule

// File: rtl/trop_out_reg.sv
module trop_out_reg #(
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PIX_W-1:0] d,
  output logic             q_valid,
  output logic [PIX_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/tern_rop_unit.sv
module tern_rop_unit
  import tern_rop_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned MIX_W = 8,
  parameter int unsigned X_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] dst_px,
  input  logic [PIX_W-1:0] src_px,
  input  logic [PIX_W-1:0] pat_px,
  input  logic [7:0]       fg_rop,
  input  logic [7:0]       bg_rop,
  input  logic [MIX_W-1:0] mix_map,
  input  logic             mix_en,
  input  logic [X_W-1:0]   x_pos,
  input  logic             x_neg,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_px
);
  rop_code_t        sel_code;
  logic [PIX_W-1:0] comb_px;

  trop_code_select #(.MIX_W(MIX_W), .X_W(X_W)) u_sel (
    .fg_rop  (fg_rop),
    .bg_rop  (bg_rop),
    .mix_map (mix_map),
    .mix_en  (mix_en),
    .x_pos   (x_pos),
    .x_neg   (x_neg),
    .code    (sel_code)
  );

  trop_combiner #(.PIX_W(PIX_W)) u_comb (
    .code (sel_code),
    .dst  (dst_px),
    .src  (src_px),
    .pat  (pat_px),
    .res  (comb_px)
  );

  trop_out_reg #(.PIX_W(PIX_W)) u_oreg (
    .clk     (clk),
    .rst     (rst),
    .load    (in_valid),
    .d       (comb_px),
    .q_valid (out_valid),
    .q       (out_px)
  );
endmodule

// File: rtl/trop_checker.sv
module trop_checker #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned MIX_W = 8,
  parameter int unsigned X_W   = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [PIX_W-1:0] dst_px,
  input logic [PIX_W-1:0] src_px,
  input logic [PIX_W-1:0] pat_px,
  input logic [7:0]       fg_rop,
  input logic [7:0]       bg_rop,
  input logic [MIX_W-1:0] mix_map,
  input logic             mix_en,
  input logic [X_W-1:0]   x_pos,
  input logic             x_neg,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_px
);
  // Lookup by direct indexing, a different formulation from the mask logic.
  function automatic logic [PIX_W-1:0] lut(input logic [7:0] c,
      input logic [PIX_W-1:0] d, input logic [PIX_W-1:0] s,
      input logic [PIX_W-1:0] p);
    logic [PIX_W-1:0] r;
    for (int i = 0; i < PIX_W; i++) r[i] = c[{p[i], s[i], d[i]}];
    return r;
  endfunction

  function automatic logic mbit(input logic [MIX_W-1:0] m,
      input logic [X_W-1:0] x, input logic neg);
    int unsigned k;
    k = int'(x) % MIX_W;
    if (neg) k = MIX_W - 1 - k;
    return m[k];
  endfunction

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_px));
  assert_same_code_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fg_rop == bg_rop) |=>
      out_px == $past(lut(fg_rop, dst_px, src_px, pat_px)));
  assert_no_mix_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mix_en) |=>
      out_px == $past(lut(fg_rop, dst_px, src_px, pat_px)));
  assert_mix_pos_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mix_en && !x_neg && fg_rop == 8'hFF && bg_rop == 8'h00) |=>
      out_px == {PIX_W{$past(mbit(mix_map, x_pos, 1'b0))}});
  assert_mix_neg_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mix_en && x_neg && fg_rop == 8'hFF && bg_rop == 8'h00) |=>
      out_px == {PIX_W{$past(mbit(mix_map, x_pos, 1'b1))}});
  assert_mix_choice_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mix_en && fg_rop == 8'h00 && bg_rop == 8'hFF) |=>
      out_px == {PIX_W{!$past(mbit(mix_map, x_pos, x_neg))}});
endmodule

bind tern_rop_unit trop_checker #(.PIX_W(PIX_W), .MIX_W(MIX_W), .X_W(X_W))
  u_trop_chk (.*);

// File: tb/tern_rop_unit_bench.sv
module tern_rop_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  dst_px = '0, src_px = '0, pat_px = '0;
  logic [7:0]  fg_rop = '0, bg_rop = '0, mix_map = '0;
  logic        mix_en = 1'b0;
  logic [15:0] x_pos = '0;
  logic        x_neg = 1'b0;
  logic        out_valid;
  logic [7:0]  out_px;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] last_px = '0;

  always #2 clk = ~clk;

  tern_rop_unit u_tern_rop_unit (.*);

  function automatic logic [7:0] ref_px(input logic [7:0] fg, input logic [7:0] bg,
      input logic [7:0] m, input logic men, input logic [15:0] x, input logic neg,
      input logic [7:0] d, input logic [7:0] s, input logic [7:0] p);
    int unsigned k;
    logic [7:0] c, r;
    k = x % 8;
    if (neg) k = 7 - k;
    c = (!men || m[k]) ? fg : bg;
    for (int i = 0; i < 8; i++) r[i] = c[{p[i], s[i], d[i]}];
    return r;
  endfunction

  task automatic push_px(input logic [7:0] d, input logic [7:0] s, input logic [7:0] p,
      input logic [7:0] fg, input logic [7:0] bg, input logic [7:0] m,
      input logic men, input logic [15:0] x, input logic neg, input string tag);
    @(negedge clk);
    in_valid = 1'b1; dst_px = d; src_px = s; pat_px = p;
    fg_rop = fg; bg_rop = bg; mix_map = m; mix_en = men; x_pos = x; x_neg = neg;
    exp_q.push_back(ref_px(fg, bg, m, men, x, neg, d, s, p));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      dst_px = 8'($urandom); src_px = 8'($urandom); pat_px = 8'($urandom);
      fg_rop = 8'($urandom); bg_rop = 8'($urandom); mix_map = 8'($urandom);
      mix_en = 1'($urandom); x_pos = 16'($urandom); x_neg = 1'($urandom);
    end
  endtask

  // Monitor: one sample per cycle, 1 ns after the rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        checks++;
        if (out_valid !== in_valid) begin
          errors++;
          $display("FAIL R2 out_valid=%0b expected %0b", out_valid, in_valid);
        end
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R2 result with empty scoreboard px=%02h expected none", out_px);
          end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            last_px = e;
            checks++;
            if (out_px !== e) begin
              errors++;
              $display("FAIL %s out_px=%02h expected %02h", t, out_px, e);
            end
          end
        end else begin
          checks++;
          if (out_px !== last_px) begin
            errors++;
            $display("FAIL R8 out_px=%02h expected held %02h", out_px, last_px);
          end
        end
      end
    end
  end

  task automatic run_all();
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_px !== 8'h00) begin
      errors++;
      $display("FAIL R1 valid=%0b px=%02h expected 0 00", out_valid, out_px);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_px !== 8'h00) begin
      errors++;
      $display("FAIL R1 after release valid=%0b px=%02h expected 0 00", out_valid, out_px);
    end
    // R3: every code, foreground and background equal, random operands.
    for (int c = 0; c < 256; c++)
      push_px(8'($urandom), 8'($urandom), 8'($urandom), 8'(c), 8'(c),
              8'($urandom), 1'b1, 16'($urandom), 1'($urandom), "R3");
    // R3 directed: operand bits walk through all eight index values.
    push_px(8'hAA, 8'hCC, 8'hF0, 8'hB4, 8'hB4, 8'h00, 1'b1, 16'd0, 1'b0, "R3");
    idle(2);
    // R4/R5 positive direction, each lane of the mix byte.
    for (int x = 0; x < 16; x++)
      push_px(8'($urandom), 8'($urandom), 8'($urandom), 8'hFF, 8'h00,
              8'h5A, 1'b1, 16'(x + 1024), 1'b0, "R5");
    // R4/R6 negative direction: x=7 reads lane 0, x=0 reads lane 7.
    for (int x = 0; x < 16; x++)
      push_px(8'($urandom), 8'($urandom), 8'($urandom), 8'hFF, 8'h00,
              8'h01, 1'b1, 16'(x), 1'b1, "R6");
    push_px(8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h80, 1'b1, 16'd7, 1'b0, "R4");
    push_px(8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h80, 1'b1, 16'd7, 1'b1, "R4");
    idle(3);
    // R4 mixed codes, random everything.
    for (int n = 0; n < 200; n++) begin
      push_px(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
              8'($urandom), 1'b1, 16'($urandom), 1'($urandom), "R4");
      if (n % 17 == 0) idle(1);
    end
    // R7: mix disabled, mix byte zero would otherwise pick background.
    for (int n = 0; n < 40; n++)
      push_px(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
              8'h00, 1'b0, 16'($urandom), 1'($urandom), "R7");
    // R8: long idle with scrambled inputs.
    idle(10);
    while (exp_q.size() != 0) idle(1);
    idle(2);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired expected completion");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule